// File: doc/BRIEF.md
# Logic Analyzer Trigger Evaluator

This block turns a vector of trigger inputs into one capture qualifier for an on-chip logic analyzer. Every trigger lane has its own enable, polarity-invert and mode controls. In level mode a lane is active while its input is at the selected level. In latching mode a lane fires on an edge of its input and stays active until it is cleared. The active lanes are then combined by either an OR or an AND reduction into a single registered qualifier. That qualifier tells the sample store, in the sampling clock domain, which cycles to record.

Each lane keeps the input value from the previous cycle so that it can detect edges. A one-cycle synchronous clear empties both this history and every latched lane. Disabled lanes are neutral in both reductions: OR skips them and AND treats them as satisfied. When no lane is enabled, the qualifier stays low. All pins are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake.

Top module: `trig_eval`

## Requirements
- R1: When `reduce_and_i` is 0 (OR mode), `store_o` is high in the cycle after an edge exactly when at least one enabled lane was active at that edge.
- R2: When `reduce_and_i` is 1 (AND mode), `store_o` is high in the cycle after an edge exactly when every enabled lane was active and at least one lane was enabled. Disabled lanes count as satisfied.
- R3: If `lane_en_i` is all zero at an edge, `store_o` is low in the next cycle, whatever the reduction mode.
- R4: A level-mode lane (`lane_latch_i` bit 0) is active while its input is 1 if `lane_inv_i` is 0, and while its input is 0 if `lane_inv_i` is 1.
- R5: An enabled, non-inverted, latching lane fires when its input is 1 at an edge and was 0 at the previous edge. It is active in that same evaluation.
- R6: An enabled, inverted, latching lane fires when its input is 0 at an edge and was 1 at the previous edge.
- R7: Once a latching lane has fired, it stays active on every following edge until a clear, even after its input returns to its idle level. Only an enabled latching lane can become latched.
- R8: A clear at an edge forces `store_o` low in the next cycle. It releases all latches and sets every lane's stored previous input to 0, so an input held at 1 registers as a rising edge at the first edge after the clear.
- R9: `store_o` is a register, reset to 0 by `rst_ni` low. It reflects the inputs sampled at the preceding rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_TRIG | Trigger inputs, one per lane |
| lane_en_i | input | NUM_TRIG | Per-lane enable |
| lane_inv_i | input | NUM_TRIG | Per-lane polarity invert |
| lane_latch_i | input | NUM_TRIG | Per-lane mode: 0 level, 1 latching edge |
| reduce_and_i | input | 1 | Reduction select: 0 OR, 1 AND |
| clear_i | input | 1 | Synchronous clear of latches and edge history |
| store_o | output | 1 | Registered combined capture qualifier |

## Verification
A corrupted latch bit or edge-history bit would not show up right away. It becomes visible on `store_o` one cycle after the next edge where that lane decides the result: for example, a latch that has dropped by mistake while the other lanes are idle, or a false edge after a clear. The bench therefore keeps its own latch and history state and compares `store_o` on every cycle. It runs exhaustive single-cycle sweeps of level lanes and long pseudo-random runs of mixed lanes with occasional clears, so any divergence is reported within one cycle of the edge where it starts.

// File: rtl/trig_eval_pkg.sv
package trig_eval_pkg;
  typedef enum logic {
    RED_ANY = 1'b0,
    RED_ALL = 1'b1
  } red_mode_e;
endpackage

// File: rtl/trig_lane.sv
module trig_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic trig_i,
  input  logic en_i,
  input  logic inv_i,
  input  logic latch_mode_i,
  output logic hit_o
);
  logic prev_q;
  logic held_q;
  logic edge_seen;

  // rising edge when not inverted, falling edge when inverted
  always_comb begin
    if (inv_i) edge_seen = prev_q & ~trig_i;
    else       edge_seen = trig_i & ~prev_q;
  end

  always_comb begin
    if (latch_mode_i) hit_o = held_q | edge_seen;
    else              hit_o = trig_i ^ inv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else if (clear_i) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= trig_i;
      if (en_i && latch_mode_i && edge_seen) held_q <= 1'b1;
    end
  end

  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && !clear_i |=> held_q); // R7
  AST_LATCH_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_q && !(en_i && latch_mode_i) |=> !held_q); // R7
  AST_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && latch_mode_i && !inv_i && !clear_i && trig_i && !prev_q |=> held_q); // R5
  AST_FALL_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && latch_mode_i && inv_i && !clear_i && !trig_i && prev_q |=> held_q); // R6
  AST_CLEAR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !held_q && !prev_q); // R8
endmodule

// File: rtl/trig_reduce.sv
module trig_reduce
  import trig_eval_pkg::*;
#(
  parameter int NUM_TRIG = 8
) (
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic [NUM_TRIG-1:0] en_i,
  input  red_mode_e           mode_i,
  output logic                fire_o
);
  logic any_en;
  logic any_hit;
  logic all_hit;

  always_comb begin
    any_en  = |en_i;
    any_hit = |(hit_i & en_i);
    all_hit = &(hit_i | ~en_i);
    case (mode_i)
      RED_ALL: fire_o = any_en & all_hit;
      default: fire_o = any_hit;
    endcase
  end
endmodule

// File: rtl/trig_eval.sv
module trig_eval
  import trig_eval_pkg::*;
#(
  parameter int NUM_TRIG = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [NUM_TRIG-1:0] lane_en_i,
  input  logic [NUM_TRIG-1:0] lane_inv_i,
  input  logic [NUM_TRIG-1:0] lane_latch_i,
  input  logic                reduce_and_i,
  input  logic                clear_i,
  output logic                store_o
);
  logic [NUM_TRIG-1:0] lane_hit;
  logic                fire;
  red_mode_e           mode;

  assign mode = red_mode_e'(reduce_and_i);

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_lane
    trig_lane u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clear_i      (clear_i),
      .trig_i       (trig_i[g]),
      .en_i         (lane_en_i[g]),
      .inv_i        (lane_inv_i[g]),
      .latch_mode_i (lane_latch_i[g]),
      .hit_o        (lane_hit[g])
    );
  end

  trig_reduce #(.NUM_TRIG(NUM_TRIG)) u_reduce (
    .hit_i  (lane_hit),
    .en_i   (lane_en_i),
    .mode_i (mode),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      store_o <= 1'b0;
    else if (clear_i) store_o <= 1'b0;
    else              store_o <= fire;
  end

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !store_o); // R8
  AST_NONE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en_i == '0 |=> !store_o); // R3
  AST_OR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reduce_and_i && (lane_hit & lane_en_i) == '0 |=> !store_o); // R1
  AST_AND_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reduce_and_i && !clear_i && lane_en_i != '0 && (lane_hit | ~lane_en_i) == '1 |=> store_o); // R2
endmodule

// File: tb/trig_eval_tb.sv
module trig_eval_tb;
  localparam int N = 3;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] trig = '0, en = '0, inv = '0, lat = '0;
  logic         red_and = 1'b0, clr = 1'b0;
  logic         store;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_prev = '0;
  logic [N-1:0] m_held = '0;
  logic [31:0]  lfsr = 32'hACE1_1234;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_eval #(.NUM_TRIG(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .lane_en_i(en),
    .lane_inv_i(inv), .lane_latch_i(lat), .reduce_and_i(red_and),
    .clear_i(clr), .store_o(store)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: store_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // drive at negedge, evaluate reference, check after next posedge
  task automatic step(input logic [N-1:0] t, input logic [N-1:0] e,
                      input logic [N-1:0] n, input logic [N-1:0] c,
                      input logic ra, input logic cl, input string req);
    logic [N-1:0] edg, hit;
    logic exp;
    trig = t; en = e; inv = n; lat = c; red_and = ra; clr = cl;
    edg = (n & m_prev & ~t) | (~n & t & ~m_prev);
    hit = (c & (m_held | edg)) | (~c & (t ^ n));
    if (cl || e == '0) exp = 1'b0;
    else if (ra)       exp = &(hit | ~e);
    else               exp = |(hit & e);
    if (cl) begin
      m_prev = '0; m_held = '0;
    end else begin
      m_prev = t; m_held = m_held | (c & e & edg);
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, store, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9: watchdog act=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", store, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset", store, 1'b0);

    // exhaustive level-mode sweep: trig, enable, invert, mode
    for (int v = 0; v < 1024; v++) begin
      logic [9:0] b;
      b = v[9:0];
      step(b[2:0], b[5:3], b[8:6], '0, b[9], 1'b0,
           (b[5:3] == '0) ? "R3" : (b[9] ? "R2 R4" : "R1 R4"));
    end

    // R5 rising edge latch, R7 hold, R8 clear and re-fire
    step(3'b000, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0, "R5 idle");
    step(3'b001, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0, "R5 rise");
    step(3'b000, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0, "R7 hold");
    step(3'b000, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0, "R7 hold2");
    step(3'b001, 3'b001, 3'b000, 3'b001, 1'b0, 1'b1, "R8 clear");
    step(3'b001, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0, "R8 refire");
    step(3'b000, 3'b001, 3'b000, 3'b001, 1'b0, 1'b1, "R8 clear2");
    // R6 falling edge on inverted latching lane
    step(3'b010, 3'b010, 3'b010, 3'b010, 1'b0, 1'b0, "R6 high");
    step(3'b000, 3'b010, 3'b010, 3'b010, 1'b0, 1'b0, "R6 fall");
    step(3'b010, 3'b010, 3'b010, 3'b010, 1'b0, 1'b0, "R7 hold inv");
    step(3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1, "R8 clear3");
    // R7 disabled lane must not latch
    step(3'b100, 3'b000, 3'b000, 3'b100, 1'b0, 1'b0, "R7 disabled");
    step(3'b000, 3'b100, 3'b000, 3'b100, 1'b0, 1'b0, "R7 no latch");
    // R2 AND with latched and level lanes
    step(3'b001, 3'b011, 3'b000, 3'b001, 1'b1, 1'b0, "R2 partial");
    step(3'b010, 3'b011, 3'b000, 3'b001, 1'b1, 1'b0, "R2 all");

    // pseudo-random mixed run with sparse clears
    for (int k = 0; k < 6000; k++) begin
      lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
      step(lfsr[2:0], lfsr[5:3] | lfsr[8:6], lfsr[11:9], lfsr[14:12],
           lfsr[15], (lfsr[23:19] == 5'd0), "R1 R2 R5 R6 R7 R8 mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule